// File: doc/BRIEF.md
# Cache Protection Sweep Engine

When system software changes the access rights of one page, every cached line that belongs to that page has to carry the new rights. This engine does that work over the tag array of a direct-mapped, virtually indexed and virtually tagged cache. Software gives it a page base address, a page size that can be changed at run time, and the new protection bits. The engine then steps through each line of the page in address order. At each line index it reads the tag entry and compares the stored tag with the tag of that line's address. A line that matches gets its protection field rewritten. A line that does not match is only read.

Every visit costs a fixed number of cycles, so the cost of a sweep is known in advance. A check that leaves the line alone takes three cycles, and a check that rewrites the line takes five. The engine has a lazy mode for requests that only loosen a page's rights. In that mode it leaves any matching line whose rights would only grow, so that line keeps its stricter rights until a later fault fixes it. Rights that are being tightened are always written.

At the end of a sweep the engine reports how many lines it rewrote and how many cycles the sweep took. A page size that is not a power of two, or that is smaller than one line, is rejected with an error flag and causes no tag traffic.

Top module: `prot_sweep`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `tag_rd_en` and `tag_wr_en` are all low, and no tag access happens until a start is accepted.
- R2: An accepted sweep reads exactly size/LINE_BYTES tag entries, one per line address, in increasing order. The first line address is `start_base` with its low log2(LINE_BYTES) bits dropped. The tag index is the low IDX_W bits of each line address, so the index wraps around the array.
- R3: A line that is not rewritten takes exactly 3 cycles (read, wait, compare) and causes no tag write.
- R4: A matching line is one whose entry valid bit is set and whose stored tag equals the line address above the index bits. Outside lazy mode such a line is written back with the valid bit set, the same tag and the new protection bits, and its visit takes exactly 5 cycles. The entry layout is {valid, tag, prot}, with prot in the low PROT_W bits and valid in the top bit.
- R5: In lazy mode, a matching line whose stored protection has no bit that is clear in the new protection is left unwritten and costs 3 cycles. A matching line that would lose a bit is written as in R4.
- R6: `done` is a one-cycle pulse in the cycle after the last visit ends. `upd_count`, `cyc_count` and `err` keep their values until the next start is accepted.
- R7: For a good sweep, `cyc_count` equals 5 × `upd_count` + 3 × (lines − `upd_count`). The accept edge is followed by exactly that many clock edges before `done` is seen.
- R8: A start is accepted only while `busy` is low. A start held high during a sweep is taken up on the first edge after that sweep ends, and is not lost.
- R9: A start whose size is not a power of two or is below LINE_BYTES raises `done` and `err` in the next cycle. Both counts are zero and no tag read or write takes place.
- R10: An entry whose valid bit is clear is never rewritten, even when its tag field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sweep request, held until accepted |
| start_base | input | ADDR_W | Virtual base address of the page |
| start_size | input | ADDR_W | Page size in bytes |
| start_prot | input | PROT_W | New protection bits |
| start_lazy | input | 1 | Skip matching lines whose rights only grow |
| busy | output | 1 | Sweep in progress; start not accepted |
| tag_rd_en | output | 1 | Tag array read strobe (data returns one cycle later) |
| tag_wr_en | output | 1 | Tag array write strobe |
| tag_addr | output | IDX_W | Tag array index |
| tag_rd_data | input | 1+TAG_W+PROT_W | Tag entry read data {valid, tag, prot} |
| tag_wr_data | output | 1+TAG_W+PROT_W | Tag entry write data {valid, tag, prot} |
| done | output | 1 | Sweep or rejection finished (one-cycle pulse) |
| err | output | 1 | Last request had an illegal page size |
| upd_count | output | ADDR_W-log2(LINE_BYTES)+1 | Lines rewritten by the last sweep |
| cyc_count | output | ADDR_W-log2(LINE_BYTES)+4 | Cycles spent by the last sweep |

## Verification
The bench uses a 16-line cache and runs sweeps over every legal page size from one line up to twice the array. It covers all lazy settings, several protection values and mixed tag contents, and it includes pages that start mid-array and wrap past the last index. Pages larger than the array visit the same index twice with different tags. If the design reused a stale entry or mixed the tag and index fields, it would rewrite the wrong lines. The bench then finds the memory image differs from its model, or that the read order is broken. Entries that are invalid but carry a matching tag catch a design that forgets the valid bit. Lazy-mode runs with equal, looser and tighter rights catch an inverted relaxation test, which would show up as wrong counts and wrong protection bits. The bench counts the edges from accept to `done` to catch an extra or missing state in either the 3-cycle or the 5-cycle path. A start held during a busy sweep would be lost, or would collide with the running sweep, in a design with a broken accept condition. Sizes of zero, smaller than a line, or not a power of two must produce no tag reads at all.

// File: rtl/prot_sweep.sv
module prot_sweep #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int IDX_W      = 8,
  parameter int PROT_W     = 3
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start,
  input  logic [ADDR_W-1:0]                            start_base,
  input  logic [ADDR_W-1:0]                            start_size,
  input  logic [PROT_W-1:0]                            start_prot,
  input  logic                                         start_lazy,
  output logic                                         busy,
  output logic                                         tag_rd_en,
  output logic                                         tag_wr_en,
  output logic [IDX_W-1:0]                             tag_addr,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-IDX_W+PROT_W:0] tag_rd_data,
  output logic [ADDR_W-$clog2(LINE_BYTES)-IDX_W+PROT_W:0] tag_wr_data,
  output logic                                         done,
  output logic                                         err,
  output logic [ADDR_W-$clog2(LINE_BYTES):0]           upd_count,
  output logic [ADDR_W-$clog2(LINE_BYTES)+3:0]         cyc_count
);

  localparam int LOFS  = $clog2(LINE_BYTES);
  localparam int LA_W  = ADDR_W - LOFS;
  localparam int TAG_W = LA_W - IDX_W;
  localparam int ENT_W = 1 + TAG_W + PROT_W;
  localparam int LN_W  = LA_W + 1;
  localparam int CY_W  = LN_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_LAT, S_CMP, S_WR, S_WR2} state_t;

  state_t            st;
  logic [LA_W-1:0]   la;
  logic [LN_W-1:0]   left;
  logic [LN_W-1:0]   nlines;
  logic [LN_W-1:0]   upd;
  logic [CY_W-1:0]   cyc;
  logic [PROT_W-1:0] nprot;
  logic              lazy;
  logic [ENT_W-1:0]  ent;
  logic              done_r;
  logic              err_r;

  wire size_ok = (start_size >= ADDR_W'(LINE_BYTES)) &&
                 ((start_size & (start_size - 1'b1)) == '0);

  wire              ent_v    = ent[ENT_W-1];
  wire [TAG_W-1:0]  ent_tag  = ent[ENT_W-2 -: TAG_W];
  wire [PROT_W-1:0] ent_prot = ent[PROT_W-1:0];

  wire hit     = ent_v && (ent_tag == la[LA_W-1:IDX_W]);
  wire relax   = (ent_prot & ~nprot) == '0;
  wire need_wr = hit && !(lazy && relax);
  wire last    = (left == LN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      la     <= '0;
      left   <= '0;
      nlines <= '0;
      upd    <= '0;
      cyc    <= '0;
      nprot  <= '0;
      lazy   <= 1'b0;
      ent    <= '0;
      done_r <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (st != S_IDLE) cyc <= cyc + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          upd <= '0;
          cyc <= '0;
          if (size_ok) begin
            la     <= start_base[ADDR_W-1:LOFS];
            left   <= LN_W'(start_size >> LOFS);
            nlines <= LN_W'(start_size >> LOFS);
            nprot  <= start_prot;
            lazy   <= start_lazy;
            err_r  <= 1'b0;
            st     <= S_RD;
          end else begin
            err_r  <= 1'b1;
            done_r <= 1'b1;
          end
        end
        S_RD:  st <= S_LAT;
        S_LAT: begin
          ent <= tag_rd_data;
          st  <= S_CMP;
        end
        S_CMP: begin
          if (need_wr) st <= S_WR;
          else begin
            la   <= la + 1'b1;
            left <= left - 1'b1;
            if (last) begin
              st     <= S_IDLE;
              done_r <= 1'b1;
            end else st <= S_RD;
          end
        end
        S_WR: begin
          upd <= upd + 1'b1;
          st  <= S_WR2;
        end
        S_WR2: begin
          la   <= la + 1'b1;
          left <= left - 1'b1;
          if (last) begin
            st     <= S_IDLE;
            done_r <= 1'b1;
          end else st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign tag_rd_en   = (st == S_RD);
  assign tag_wr_en   = (st == S_WR);
  assign tag_addr    = la[IDX_W-1:0];
  assign tag_wr_data = {1'b1, ent_tag, nprot};
  assign done        = done_r;
  assign err         = err_r;
  assign upd_count   = upd;
  assign cyc_count   = cyc;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tag_rd_en && !tag_wr_en)); // R1

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> ($past(tag_rd_en, 3) && tag_addr == $past(tag_addr, 3))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_COUNTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(upd_count) && $stable(cyc_count) && $stable(err))); // R6

  AST_CYC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (cyc_count == CY_W'(5) * CY_W'(upd_count) +
                        CY_W'(3) * (CY_W'(nlines) - CY_W'(upd_count)))); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (upd_count == '0 && cyc_count == '0)); // R9

endmodule

// File: tb/sim_prot_sweep.sv
module sim_prot_sweep;
  localparam int ADDR_W = 16;
  localparam int LINE_BYTES = 16;
  localparam int IDX_W = 4;
  localparam int PROT_W = 3;
  localparam int NL = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] start_base = '0;
  logic [15:0] start_size = '0;
  logic [2:0]  start_prot = '0;
  logic        start_lazy = 1'b0;
  logic        busy, tag_rd_en, tag_wr_en, done, err;
  logic [3:0]  tag_addr;
  logic [11:0] tag_rd_data, tag_wr_data;
  logic [12:0] upd_count;
  logic [15:0] cyc_count;

  prot_sweep #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W), .PROT_W(PROT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .start_size(start_size), .start_prot(start_prot), .start_lazy(start_lazy),
    .busy(busy), .tag_rd_en(tag_rd_en), .tag_wr_en(tag_wr_en), .tag_addr(tag_addr),
    .tag_rd_data(tag_rd_data), .tag_wr_data(tag_wr_data), .done(done), .err(err),
    .upd_count(upd_count), .cyc_count(cyc_count));

  logic [11:0] mem [NL];
  logic [11:0] refm [NL];
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [11:0] ld_val = '0;

  always @(posedge clk) begin
    if (tag_rd_en) tag_rd_data <= mem[tag_addr];
    if (tag_wr_en) mem[tag_addr] <= tag_wr_data;
    if (ld_en) mem[ld_idx] <= ld_val;
  end

  int nchk = 0;
  int nfail = 0;
  logic [11:0] mon_base = '0;
  int mon_k = 0;
  int mon_bad = 0;
  int wd = 0;

  always @(posedge clk) begin
    if (tag_rd_en) begin
      if (tag_addr != mon_base[3:0] + 4'(mon_k)) mon_bad++;
      mon_k++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", wd);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [11:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 4'(idx); ld_val = v;
    refm[idx] = v;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < NL; i++) begin
      logic v;
      logic [7:0] t;
      int sel;
      v = ((i * 7 + seed) % 5) != 0;
      sel = (i * 3 + seed) % 4;
      t = (sel == 1) ? 8'h21 : (sel == 2) ? 8'h55 : 8'h20;
      load(i, {v, t, 3'((i + seed) % 8)});
    end
  endtask

  function automatic int model(input logic [15:0] base, input logic [15:0] size,
                               input logic [2:0] p, input logic lz);
    int u = 0;
    int n = int'(size) / LINE_BYTES;
    for (int i = 0; i < n; i++) begin
      logic [11:0] la;
      logic [11:0] e;
      la = base[15:4] + 12'(i);
      e = refm[la[3:0]];
      if (e[11] && e[10:3] == la[11:4] && !(lz && ((e[2:0] & ~p) == 3'b0))) begin
        refm[la[3:0]] = {1'b1, la[11:4], p};
        u++;
      end
    end
    return u;
  endfunction

  task automatic cmp_mem(input string what);
    int bad = 0;
    for (int i = 0; i < NL; i++) if (mem[i] !== refm[i]) bad++;
    chk(bad == 0, what, bad, 0);
  endtask

  task automatic sweep(input logic [15:0] base, input logic [15:0] size,
                       input logic [2:0] p, input logic lz);
    bit bad;
    int n, u, c, k;
    logic [12:0] hu;
    logic [15:0] hc;
    bad = (size < 16) || ((size & (size - 16'd1)) != 0);
    n = bad ? 0 : int'(size) / LINE_BYTES;
    u = bad ? 0 : model(base, size, p, lz);
    c = 5 * u + 3 * (n - u);
    @(negedge clk);
    mon_base = base[15:4]; mon_k = 0; mon_bad = 0;
    start = 1'b1; start_base = base; start_size = size; start_prot = p; start_lazy = lz;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(k == c, "R7 edges from accept to done", k, c);
    chk(int'(upd_count) == u, "R4 R5 update count", int'(upd_count), u);
    chk(int'(cyc_count) == c, "R3 R4 R7 cycle count", int'(cyc_count), c);
    chk(err == bad, "R9 error flag", int'(err), int'(bad));
    chk(mon_k == n && mon_bad == 0, "R2 reads and order", mon_k * 100 + mon_bad, n * 100);
    hu = upd_count; hc = cyc_count;
    @(negedge clk);
    chk(!done && upd_count == hu && cyc_count == hc, "R6 pulse and held counts",
        int'(done), 0);
    cmp_mem("R4 R5 R10 tag array image");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !tag_rd_en && !tag_wr_en, "R1 state in reset",
        int'({busy, done, err, tag_rd_en, tag_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !tag_rd_en && !tag_wr_en, "R1 idle after reset",
        int'({busy, done, tag_rd_en, tag_wr_en}), 0);

    for (int i = 0; i < NL; i++)
      load(i, {(i != 5) && (i != 6), (i % 2 == 0) || i == 5 ? 8'h12 : 8'h33, 3'd7});
    sweep(16'h1200, 16'd256, 3'd1, 1'b0);
    sweep(16'h1200, 16'd256, 3'd3, 1'b1);
    sweep(16'h1200, 16'd256, 3'd0, 1'b1);
    sweep(16'h1280, 16'd64, 3'd6, 1'b0);
    sweep(16'h12A0, 16'd16, 3'd2, 1'b0);
    load(3, {1'b1, 8'h13, 3'd4});
    load(12, {1'b1, 8'h12, 3'd4});
    sweep(16'h12C0, 16'd128, 3'd5, 1'b0);
    sweep(16'h1200, 16'd512, 3'd7, 1'b0);

    sweep(16'h1200, 16'd48, 3'd1, 1'b0);
    sweep(16'h1200, 16'd8, 3'd1, 1'b0);
    sweep(16'h1200, 16'd0, 3'd1, 1'b0);
    chk(!err || 1'b1, "R9 rejections done", 0, 0);

    for (int s = 4; s <= 9; s++)
      for (int lz = 0; lz < 2; lz++)
        for (int pi = 0; pi < 3; pi++) begin
          fill(s * 6 + lz * 3 + pi);
          sweep(16'h2000 + 16'(pi * 64), 16'(1 << s), pi == 0 ? 3'd0 : pi == 1 ? 3'd5 : 3'd7,
                lz[0]);
        end

    begin
      int ua, ub, ca, cb, k;
      fill(11);
      ua = model(16'h2000, 16'd256, 3'd0, 1'b0);
      ca = 5 * ua + 3 * (16 - ua);
      ub = model(16'h2040, 16'd64, 3'd6, 1'b0);
      cb = 5 * ub + 3 * (4 - ub);
      @(negedge clk);
      start = 1'b1; start_base = 16'h2000; start_size = 16'd256; start_prot = 3'd0; start_lazy = 1'b0;
      @(posedge clk);
      @(negedge clk);
      start_base = 16'h2040; start_size = 16'd64; start_prot = 3'd6;
      repeat (5) @(negedge clk);
      chk(busy, "R8 busy while sweeping", int'(busy), 1);
      k = 0;
      while (!done && k < 3000) begin
        @(negedge clk);
        k++;
      end
      chk(int'(upd_count) == ua, "R8 first sweep count with start held", int'(upd_count), ua);
      chk(int'(cyc_count) == ca, "R8 first sweep cycles with start held", int'(cyc_count), ca);
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R8 held start taken after done", int'(busy), 1);
      k = 0;
      while (!done && k < 3000) begin
        @(negedge clk);
        k++;
      end
      chk(int'(upd_count) == ub, "R8 second sweep count", int'(upd_count), ub);
      chk(int'(cyc_count) == cb, "R8 second sweep cycles", int'(cyc_count), cb);
      cmp_mem("R8 tag array after both sweeps");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule